// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue with Branch Flush

This block is the fetch side of a split fetch/execute front end. It runs by itself: it holds a fetch pointer, issues single-byte reads to an instruction memory port, and places each returned byte in a six-entry queue. The execute side never reads memory. It takes opcode bytes from the head of the queue through a pop handshake, one byte per accepted pop.

When the execute side resolves a taken branch, it asserts `redirect` with the target address. In that same cycle the queue is emptied and the fetch pointer is loaded with the target. Requests already in flight are not recalled from memory. Every request carries an epoch bit that flips on each redirect, and responses from before the redirect are counted out as they return and are discarded. The queue then refills from the target.

A counter measures the refill penalty. It counts the cycles in which the consumer wanted a byte but had none because of a redirect.

Top module: `pq_prefetch_unit`

## Requirements
- R1: After a synchronous reset the queue is empty (`pop_valid` low), `refill_stall_cycles` is 0, and in the first cycle after reset a request is presented with `mem_req_addr` equal to the parameter `RESET_VEC` (default 16'h0100).
- R2: Requests go to consecutive addresses. The address advances by exactly one for each accepted request (`mem_req_valid` and `mem_req_ready` both high), stays unchanged while a request waits for `mem_req_ready`, and wraps modulo 2^ADDR_W.
- R3: A request is offered only while queued bytes plus live outstanding requests number fewer than DEPTH (6). With no pops after a redirect, exactly 6 requests are accepted and the queue never overflows.
- R4: `pop_valid` is high when the queue holds a byte and no redirect is present. `pop_data` is then the oldest byte. Bytes come out in fetch order, and each is the memory byte at its address.
- R5: A redirect empties the queue in the cycle it is asserted. `pop_valid` is low in that cycle even if `pop_req` is high, and the next byte popped is the byte at the target address.
- R6: `mem_req_tag` inverts on every redirect. No response to a request accepted before a redirect ever enters the queue, including across back-to-back redirects.
- R7: After a redirect, with memory always ready and latency LAT, the first target byte is valid LAT+2 cycles after the redirect cycle.
- R8: `refill_stall_cycles` goes up by one in each cycle with `pop_req` high and `pop_valid` low, from the redirect cycle up to the first accepted pop after it. Empty-queue cycles not caused by a redirect are not counted.
- R9: Once the queue is full, each accepted pop frees exactly one slot, so exactly one further request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address to read |
| mem_req_tag | output | 1 | Epoch bit; the memory returns it with the response |
| mem_rsp_valid | input | 1 | Response byte present (fixed latency, in order) |
| mem_rsp_tag | input | 1 | Epoch bit of the request being answered |
| mem_rsp_data | input | 8 | Returned instruction byte |
| pop_req | input | 1 | Consumer wants a byte |
| pop_valid | output | 1 | Head byte is valid; pop taken when pop_req is also high |
| pop_data | output | 8 | Head byte |
| redirect | input | 1 | Taken branch: flush and restart fetching |
| redirect_addr | input | ADDR_W | Branch target address |
| refill_stall_cycles | output | STALL_W | Saturating count of refill stall cycles |

## Verification
The bench targets responses still in flight when a redirect arrives, including two redirects one cycle apart. A design that relies on the epoch bit alone would let a byte from two redirects back slip into the queue and pop the wrong opcode. It also drives a redirect and a pop in the same cycle on a full queue: a design where the pop wins would hand out a stale byte. Running with no pops checks the credit limit, since an off-by-one issues a seventh request. Stalling the memory port checks that the address is held while the request waits, because a pointer that moves early skips bytes. Exact refill stall counts catch a meter that counts one cycle too many or too few, or that keeps counting after the first pop.

// File: rtl/pq_pkg.sv
package pq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        logic  tag;
        byte_t data;
    } mem_rsp_t;

    function automatic int unsigned cnt_width(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pq_byte_queue.sv
module pq_byte_queue
    import pq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH),
    localparam int OCC_W = cnt_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  byte_t            push_data,
    input  logic             pop,
    output logic             empty,
    output byte_t            head_data,
    output logic [OCC_W-1:0] occupancy
);

    byte_t            slot_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [OCC_W-1:0] occ_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            slot_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= step(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= step(rd_ptr_q);
            end
            occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
        end
    end

    assign empty     = (occ_q == '0);
    assign head_data = slot_q[rd_ptr_q];
    assign occupancy = occ_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (occ_q < OCC_W'(DEPTH))); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ_q == '0)); // R5

endmodule

// File: rtl/pq_fetch_ctrl.sv
module pq_fetch_ctrl
    import pq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DEPTH     = 6,
    parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0100,
    localparam int OCC_W = cnt_width(DEPTH),
    localparam int SUM_W = OCC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic [OCC_W-1:0]  occupancy,
    input  logic              req_ready,
    input  mem_rsp_t          rsp,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_tag,
    output logic              push,
    output byte_t             push_data
);

    logic [ADDR_W-1:0] addr_q;
    logic              epoch_q;
    logic [OCC_W-1:0]  inflight_q;
    logic [OCC_W-1:0]  discard_q;
    logic [OCC_W-1:0]  live;
    logic [SUM_W-1:0]  committed;
    logic              fire;

    assign live      = inflight_q - discard_q;
    assign committed = {1'b0, occupancy} + {1'b0, live};
    assign req_valid = !redirect && (committed < SUM_W'(DEPTH));
    assign fire      = req_valid && req_ready;
    assign req_addr  = addr_q;
    assign req_tag   = epoch_q;

    assign push      = rsp.valid && !redirect && (discard_q == '0) && (rsp.tag == epoch_q);
    assign push_data = rsp.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= RESET_VEC;
            epoch_q    <= 1'b0;
            inflight_q <= '0;
            discard_q  <= '0;
        end else begin
            inflight_q <= inflight_q + OCC_W'(fire) - OCC_W'(rsp.valid);
            if (redirect) begin
                addr_q    <= redirect_addr;
                epoch_q   <= ~epoch_q;
                discard_q <= inflight_q - OCC_W'(rsp.valid);
            end else begin
                if (fire) begin
                    addr_q <= addr_q + 1'b1;
                end
                if (rsp.valid && (discard_q != '0)) begin
                    discard_q <= discard_q - 1'b1;
                end
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (fire && !redirect) |=> (addr_q == $past(addr_q) + 1'b1)); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !redirect) |=> $stable(addr_q)); // R2

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        committed <= SUM_W'(DEPTH)); // R3

    AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (addr_q == $past(redirect_addr))); // R5

    AST_EPOCH_FLIP: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (epoch_q != $past(epoch_q))); // R6

endmodule

// File: rtl/pq_refill_meter.sv
module pq_refill_meter #(
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               redirect,
    input  logic               pop_req,
    input  logic               pop_valid,
    output logic [STALL_W-1:0] stall_cycles
);

    logic               pending_q;
    logic [STALL_W-1:0] cnt_q;
    logic               starve;

    assign starve = pop_req && !pop_valid && (redirect || pending_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (redirect) begin
                pending_q <= 1'b1;
            end else if (pop_req && pop_valid) begin
                pending_q <= 1'b0;
            end
            if (starve && (cnt_q != '1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stall_cycles = cnt_q;

    AST_STALL_MONO: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_q >= $past(cnt_q))); // R8

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pop_req && pop_valid && !pending_q) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/pq_prefetch_unit.sv
module pq_prefetch_unit
    import pq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DEPTH     = 6,
    parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0100,
    parameter int                STALL_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic               mem_req_tag,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_tag,
    input  logic [7:0]         mem_rsp_data,
    input  logic               pop_req,
    output logic               pop_valid,
    output logic [7:0]         pop_data,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  redirect_addr,
    output logic [STALL_W-1:0] refill_stall_cycles
);

    localparam int OCC_W = cnt_width(DEPTH);

    mem_rsp_t         rsp;
    logic             push;
    byte_t            push_data;
    logic             q_empty;
    byte_t            q_head;
    logic [OCC_W-1:0] q_occ;
    logic             pop_take;

    assign rsp = '{valid: mem_rsp_valid, tag: mem_rsp_tag, data: mem_rsp_data};

    pq_fetch_ctrl #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .RESET_VEC (RESET_VEC)
    ) i_fetch (
        .clk           (clk),
        .rst           (rst),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .occupancy     (q_occ),
        .req_ready     (mem_req_ready),
        .rsp           (rsp),
        .req_valid     (mem_req_valid),
        .req_addr      (mem_req_addr),
        .req_tag       (mem_req_tag),
        .push          (push),
        .push_data     (push_data)
    );

    pq_byte_queue #(
        .DEPTH (DEPTH)
    ) i_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (redirect),
        .push      (push),
        .push_data (push_data),
        .pop       (pop_take),
        .empty     (q_empty),
        .head_data (q_head),
        .occupancy (q_occ)
    );

    assign pop_valid = !q_empty && !redirect;
    assign pop_data  = q_head;
    assign pop_take  = pop_req && pop_valid;

    pq_refill_meter #(
        .STALL_W (STALL_W)
    ) i_meter (
        .clk          (clk),
        .rst          (rst),
        .redirect     (redirect),
        .pop_req      (pop_req),
        .pop_valid    (pop_valid),
        .stall_cycles (refill_stall_cycles)
    );

    AST_FIFO_ORDER_SYNC: assert property (@(posedge clk) disable iff (rst)
        (pop_take && !push) |=> (q_occ == $past(q_occ) - 1'b1)); // R4

    AST_PUSH_POP_BAL: assert property (@(posedge clk) disable iff (rst)
        (pop_take && push) |=> (q_occ == $past(q_occ))); // R9

endmodule

// File: tb/test_pq_prefetch_unit.sv
module test_pq_prefetch_unit;

    localparam int          ADDR_W    = 16;
    localparam int          DEPTH     = 6;
    localparam logic [15:0] RESET_VEC = 16'h0100;
    localparam int          STALL_W   = 16;
    localparam int          LAT       = 2;
    localparam int          NVEC      = 6;

    // {target[31:16], pops[15:8], ready_mode[7:4], check_stall[3:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0200, 8'd10, 4'd0, 4'd1},
        {16'h13FE, 8'd12, 4'd1, 4'd0},
        {16'hFFFC, 8'd9,  4'd0, 4'd1},
        {16'h0040, 8'd20, 4'd2, 4'd0},
        {16'h7A31, 8'd7,  4'd0, 4'd1},
        {16'h0001, 8'd15, 4'd1, 4'd0}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               mem_req_valid;
    logic               mem_req_ready;
    logic [ADDR_W-1:0]  mem_req_addr;
    logic               mem_req_tag;
    logic               mem_rsp_valid;
    logic               mem_rsp_tag;
    logic [7:0]         mem_rsp_data;
    logic               pop_req = 1'b0;
    logic               pop_valid;
    logic [7:0]         pop_data;
    logic               redirect = 1'b0;
    logic [ADDR_W-1:0]  redirect_addr = '0;
    logic [STALL_W-1:0] refill_stall_cycles;

    int checks = 0;
    int failures = 0;
    logic [3:0]  ready_mode = 4'd0;
    logic [31:0] cyc = 0;
    int          hs_cnt = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    pq_prefetch_unit #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .RESET_VEC (RESET_VEC),
        .STALL_W   (STALL_W)
    ) i_pq_prefetch_unit (
        .clk                 (clk),
        .rst                 (rst),
        .mem_req_valid       (mem_req_valid),
        .mem_req_ready       (mem_req_ready),
        .mem_req_addr        (mem_req_addr),
        .mem_req_tag         (mem_req_tag),
        .mem_rsp_valid       (mem_rsp_valid),
        .mem_rsp_tag         (mem_rsp_tag),
        .mem_rsp_data        (mem_rsp_data),
        .pop_req             (pop_req),
        .pop_valid           (pop_valid),
        .pop_data            (pop_data),
        .redirect            (redirect),
        .redirect_addr       (redirect_addr),
        .refill_stall_cycles (refill_stall_cycles)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: fixed latency LAT, in order, echoes tag
    logic       pv [LAT];
    logic       pt [LAT];
    logic [7:0] pd [LAT];

    always_comb begin
        case (ready_mode)
            4'd0:    mem_req_ready = 1'b1;
            4'd1:    mem_req_ready = cyc[0];
            4'd2:    mem_req_ready = (cyc[1:0] != 2'b00);
            default: mem_req_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
        end else begin
            pv[0] <= mem_req_valid && mem_req_ready;
            pt[0] <= mem_req_tag;
            pd[0] <= mem_byte(mem_req_addr);
            for (int k = 1; k < LAT; k++) begin
                pv[k] <= pv[k-1];
                pt[k] <= pt[k-1];
                pd[k] <= pd[k-1];
            end
            if (mem_req_valid && mem_req_ready) hs_cnt <= hs_cnt + 1;
        end
    end

    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_tag   = pt[LAT-1];
    assign mem_rsp_data  = pd[LAT-1];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // pops one byte, leaves pop_req high
    task automatic pop_one(input string req, input logic [7:0] exp);
        int guard = 0;
        pop_req = 1'b1;
        while (!pop_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(req, {24'd0, pop_data}, {24'd0, exp});
        @(negedge clk);
    endtask

    task automatic do_redirect(input logic [15:0] tgt, input logic want_pop);
        redirect      = 1'b1;
        redirect_addr = tgt;
        pop_req       = want_pop;
        @(negedge clk);
        redirect = 1'b0;
    endtask

    initial begin : watchdog
        wait (cyc > 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] s0;
        int h0;
        logic t0;
        rst = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
        // R1: reset state observed before the first active edge
        chk("R1 pop_valid", {31'd0, pop_valid}, 32'd0);
        chk("R1 stall", {16'd0, refill_stall_cycles}, 32'd0);
        chk("R1 req_valid", {31'd0, mem_req_valid}, 32'd1);
        chk("R1 req_addr", {16'd0, mem_req_addr}, {16'd0, RESET_VEC});

        // R4: stream from reset vector; R8: no redirect, no stall counted
        for (int i = 0; i < 4; i++) pop_one("R4 reset stream", mem_byte(RESET_VEC + 16'(i)));
        pop_req = 1'b0;
        chk("R8 no redirect stall", {16'd0, refill_stall_cycles}, 32'd0);

        // table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] tgt;
            tgt = VEC[v][31:16];
            ready_mode = VEC[v][7:4];
            s0 = refill_stall_cycles;
            t0 = mem_req_tag;
            do_redirect(tgt, 1'b1);
            chk("R6 tag flip", {31'd0, mem_req_tag}, {31'd0, ~t0});
            for (int i = 0; i < int'(VEC[v][15:8]); i++)
                pop_one("R5 R2 R4 target stream", mem_byte(tgt + 16'(i)));
            pop_req = 1'b0;
            if (VEC[v][3:0] != 4'd0)
                chk("R7 R8 refill stall", {16'd0, refill_stall_cycles - s0}, LAT + 2);
        end
        ready_mode = 4'd0;

        // R3: no pops, exactly DEPTH requests accepted
        wait_cycles(10);
        h0 = hs_cnt;
        do_redirect(16'h3000, 1'b0);
        wait_cycles(20);
        chk("R3 requests when full", hs_cnt - h0, DEPTH);
        chk("R3 queue valid", {31'd0, pop_valid}, 32'd1);
        // R9: one pop frees one slot
        pop_one("R9 head byte", mem_byte(16'h3000));
        pop_req = 1'b0;
        wait_cycles(10);
        chk("R9 one refill request", hs_cnt - h0, DEPTH + 1);

        // R5: redirect and pop together on a full queue
        redirect = 1'b1;
        redirect_addr = 16'h5000;
        pop_req = 1'b1;
        #1;
        chk("R5 redirect beats pop", {31'd0, pop_valid}, 32'd0);
        @(negedge clk);
        redirect = 1'b0;
        for (int i = 0; i < 3; i++) pop_one("R5 after flush", mem_byte(16'h5000 + 16'(i)));
        pop_req = 1'b0;

        // R6: stale responses across back-to-back redirects
        do_redirect(16'h6000, 1'b0);
        wait_cycles(1);
        do_redirect(16'h6100, 1'b0);
        do_redirect(16'h6200, 1'b0);
        do_redirect(16'h6300, 1'b0);
        for (int i = 0; i < 8; i++) pop_one("R6 stale dropped", mem_byte(16'h6300 + 16'(i)));
        pop_req = 1'b0;

        // R2: address held under backpressure
        ready_mode = 4'd3;
        wait_cycles(4);
        h0 = hs_cnt;
        do_redirect(16'h7000, 1'b0);
        wait_cycles(3);
        chk("R2 addr held", {16'd0, mem_req_addr}, 32'h7000);
        chk("R2 no accept", hs_cnt - h0, 0);
        ready_mode = 4'd0;
        for (int i = 0; i < 5; i++) pop_one("R2 after stall", mem_byte(16'h7000 + 16'(i)));
        pop_req = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule